// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router with XY Routing

This block is a single switching node for a two-dimensional mesh. It has five bidirectional ports (local, north, east, south, west). Packets arrive as sequences of flits. The first flit of a packet names the destination tile, and the router compares that tile with its own position, which is set by parameters. The comparison picks an output port. Traffic always travels east or west until the X coordinates agree, and only then north or south. This fixed order keeps the dependencies between channels free of cycles across the mesh.

Each input port buffers a few flits in a small queue. When a head flit reaches the front of its queue, it asks for its output port. A round-robin arbiter on each output grants one requester. The winning input then keeps that output for the whole packet: every following flit uses the same path, and the tail flit gives the output back. If a downstream ready is low, the packet stays where it is, spread over the buffers along its route, and still holds its output. Every link uses a valid/ready pair, and a flit crosses the link only in a cycle where both are high.

Top module: `mesh_xy_router`

## Requirements
- R1: While reset is asserted and after its release with no traffic, every out_valid bit is 0 and every in_ready bit is 1. Port index order on all vectors is 0 = local, 1 = north, 2 = east, 3 = south, 4 = west.
- R2: A flit is {type[1:0], payload[DATA_W-1:0]}, with the type in the top two bits. A head flit carries destination X in payload bits [COORD_W-1:0]. If that X is greater than MY_X the packet leaves on east (2). If it is smaller, the packet leaves on west (4). The destination Y does not change this choice.
- R3: When the destination X equals MY_X, the destination Y in payload bits [2*COORD_W-1:COORD_W] picks the output. A Y greater than MY_Y selects north (1), and a smaller Y selects south (3).
- R4: When both destination coordinates equal the router's own coordinates, the packet leaves on local (0).
- R5: The type codes are 00 = body, 01 = head, 10 = tail and 11 = single-flit packet. Body and tail flits carry no routing information. They follow their head to the same output in the order they were sent, with their content unchanged.
- R6: Once a head flit wins an output, that output carries only flits from the same input until the tail passes. Flits of different packets never interleave on an output.
- R7: When several inputs compete for a free output, grants rotate. After input i has been granted, the next grant goes to the first requesting input after i in cyclic index order. After reset, input 0 has the highest priority.
- R8: Whenever out_valid is high and out_ready is low, the output holds the same flit with out_valid high in the next cycle. An input whose queue holds FIFO_DEPTH flits drops in_ready.
- R9: With the output ready held high, a packet that has won its output leaves at one flit per cycle, with no gaps.
- R10: A single-flit packet (type 11) takes its output and gives it back in the same transfer, so the next packet can win that output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | A flit is offered on each input port |
| in_flit | input | 5*(DATA_W+2) | Incoming flits, port p at bits [p*(DATA_W+2) +: DATA_W+2] |
| in_ready | output | 5 | The input queue can take a flit |
| out_valid | output | 5 | A flit is offered on each output port |
| out_flit | output | 5*(DATA_W+2) | Outgoing flits, same packing as in_flit |
| out_ready | input | 5 | The downstream receiver takes the flit |

## Verification
The assertions assume well-formed packet traffic on every input. Each packet starts with a head or single flit, carries only body flits in the middle, and ends with a tail. A sender also keeps its flit steady until it is accepted. A body flit that arrives with no open packet would stall its input forever, and nothing checks for that case. The bench sends traffic only through a packet task that always builds head, bodies and tail in that order. Each flit stays in the bench's send queue until the design accepts it, so no invalid stream reaches the design.

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 3,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [4:0]                    in_valid,
  input  logic [5*(DATA_W+2)-1:0]       in_flit,
  output logic [4:0]                    in_ready,
  output logic [4:0]                    out_valid,
  output logic [5*(DATA_W+2)-1:0]       out_flit,
  input  logic [4:0]                    out_ready
);
  localparam int NP     = 5;
  localparam int FLIT_W = DATA_W + 2;
  localparam int PW     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW     = $clog2(FIFO_DEPTH + 1);
  localparam logic [2:0] P_LOC = 3'd0;
  localparam logic [2:0] P_N   = 3'd1;
  localparam logic [2:0] P_E   = 3'd2;
  localparam logic [2:0] P_S   = 3'd3;
  localparam logic [2:0] P_W   = 3'd4;
  localparam logic [COORD_W-1:0] X0 = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] Y0 = COORD_W'(MY_Y);

  logic [FLIT_W-1:0] head_flit [NP];
  logic [NP-1:0]     head_vld;
  logic [2:0]        dest_port [NP];
  logic [NP-1:0]     pop_in;
  logic [NP-1:0]     busy_in;
  logic [NP-1:0]     req_to [NP];
  logic [NP-1:0]     lock_v;
  logic [2:0]        owner_v [NP];
  logic [3*NP-1:0]   owner_flat;
  logic [NP-1:0]     xfer_out;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [FLIT_W-1:0] mem [FIFO_DEPTH];
    logic [PW-1:0]     rp_q, wp_q;
    logic [CW-1:0]     cnt_q;
    logic              push;
    logic [COORD_W-1:0] dx, dy;

    assign in_ready[i] = (cnt_q != CW'(FIFO_DEPTH));
    assign push        = in_valid[i] & in_ready[i];
    assign head_flit[i] = mem[rp_q];
    assign head_vld[i]  = (cnt_q != '0);

    assign dx = head_flit[i][COORD_W-1:0];
    assign dy = head_flit[i][2*COORD_W-1:COORD_W];
    assign dest_port[i] = (dx > X0) ? P_E :
                          (dx < X0) ? P_W :
                          (dy > Y0) ? P_N :
                          (dy < Y0) ? P_S : P_LOC;

    always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= in_flit[i*FLIT_W +: FLIT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp_q  <= '0;
        wp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push) wp_q <= (wp_q == PW'(FIFO_DEPTH-1)) ? '0 : wp_q + 1'b1;
        if (pop_in[i]) rp_q <= (rp_q == PW'(FIFO_DEPTH-1)) ? '0 : rp_q + 1'b1;
        cnt_q <= cnt_q + CW'(push) - CW'(pop_in[i]);
      end
    end
  end

  always_comb begin
    busy_in = '0;
    pop_in  = '0;
    for (int o = 0; o < NP; o++) begin
      if (lock_v[o])   busy_in[owner_v[o]] = 1'b1;
      if (xfer_out[o]) pop_in[owner_v[o]]  = 1'b1;
    end
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req_to[o][i] = head_vld[i] & head_flit[i][FLIT_W-2] & ~busy_in[i] &
                       (dest_port[i] == 3'(o));
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic       lock_q;
    logic [2:0] owner_q, rr_q, gnt_idx;
    logic       gnt_vld, release_path;

    always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = rr_q;
      for (int k = 1; k <= NP; k++) begin
        if (!gnt_vld && req_to[o][(int'(rr_q) + k) % NP]) begin
          gnt_vld = 1'b1;
          gnt_idx = 3'((int'(rr_q) + k) % NP);
        end
      end
    end

    assign out_valid[o] = lock_q & head_vld[owner_q];
    assign out_flit[o*FLIT_W +: FLIT_W] = head_flit[owner_q];
    assign xfer_out[o]  = out_valid[o] & out_ready[o];
    assign release_path = xfer_out[o] & head_flit[owner_q][FLIT_W-1];

    assign lock_v[o]  = lock_q;
    assign owner_v[o] = owner_q;
    assign owner_flat[o*3 +: 3] = owner_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q  <= 1'b0;
        owner_q <= 3'd0;
        rr_q    <= 3'(NP-1);
      end else if (!lock_q) begin
        if (gnt_vld) begin
          lock_q  <= 1'b1;
          owner_q <= gnt_idx;
          rr_q    <= gnt_idx;
        end
      end else if (release_path) begin
        lock_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mesh_xy_router_chk.sv
module mesh_xy_router_chk #(
  parameter int NP     = 5,
  parameter int FLIT_W = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NP-1:0]        out_valid,
  input logic [NP-1:0]        out_ready,
  input logic [NP*FLIT_W-1:0] out_flit,
  input logic [NP-1:0]        lock_vec,
  input logic [3*NP-1:0]      owner_vec
);
  for (genvar o = 0; o < NP; o++) begin : g_o
    logic xfer, tail;
    assign xfer = out_valid[o] & out_ready[o];
    assign tail = out_flit[o*FLIT_W + FLIT_W - 1];

    a_r8_hold_flit: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));

    a_r6_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[o] && !(xfer && tail) |=> lock_vec[o] && $stable(owner_vec[o*3 +: 3]));

    a_r10_release_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && tail |=> !lock_vec[o]);

    a_r6_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> lock_vec[o]);

    a_r5_head_opens: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_vec[o]) && out_valid[o] |-> out_flit[o*FLIT_W + FLIT_W - 2]);
  end

  for (genvar i = 0; i < NP; i++) begin : g_i
    logic [NP-1:0] claim;
    always_comb begin
      for (int o = 0; o < NP; o++) claim[o] = lock_vec[o] && (owner_vec[o*3 +: 3] == 3'(i));
    end
    a_r6_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(claim));
  end
endmodule

bind mesh_xy_router mesh_xy_router_chk #(.NP(5), .FLIT_W(DATA_W + 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit),
  .lock_vec  (lock_v),
  .owner_vec (owner_flat)
);

// File: tb/sim_mesh_xy_router.sv
module sim_mesh_xy_router;
  localparam int DW = 16;
  localparam int FW = DW + 2;
  localparam int MX = 2;
  localparam int MY = 2;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] in_valid = '0;
  logic [5*FW-1:0] in_flit = '0;
  logic [4:0] in_ready, out_valid;
  logic [5*FW-1:0] out_flit;
  logic [4:0] out_ready = '0;

  mesh_xy_router #(.DATA_W(DW), .COORD_W(3), .MY_X(MX), .MY_Y(MY), .FIFO_DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready));

  always #10 clk = ~clk;

  typedef logic [FW-1:0] fq_t [$];
  fq_t sendq [5];
  fq_t expq [25];
  int cur_src [5];
  bit sent_last [5];
  bit prev_stall [5];
  logic [FW-1:0] prev_flit [5];
  int delivered [5];
  int head_log [$];
  int east_cyc [$];
  int n_checks = 0, n_fail = 0, cycle = 0, rdy_mode = 0;
  logic [4:0] rdy_force = '1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int route(int dx, int dy);
    if (dx > MX) return 2;
    if (dx < MX) return 4;
    if (dy > MY) return 1;
    if (dy < MY) return 3;
    return 0;
  endfunction

  task automatic send_pkt(int src, int dx, int dy, int nfl, int tag);
    int o;
    o = route(dx, dy);
    for (int k = 0; k < nfl; k++) begin
      logic [1:0] ty;
      logic [DW-1:0] pl;
      if (nfl == 1) ty = 2'b11;
      else if (k == 0) ty = 2'b01;
      else if (k == nfl-1) ty = 2'b10;
      else ty = 2'b00;
      if (k == 0) pl = {10'(tag), 3'(dy), 3'(dx)};
      else pl = {10'(tag), 6'(k)};
      sendq[src].push_back({ty, pl});
      expq[src*5+o].push_back({ty, pl});
    end
  endtask

  task automatic model_take(int o, logic [FW-1:0] f);
    int s;
    bit ok;
    delivered[o]++;
    if (o == 2) east_cyc.push_back(cycle);
    if (cur_src[o] < 0) begin
      ok = 1'b0;
      for (int c = 0; c < 5; c++) begin
        if (!ok && f[FW-2] && expq[c*5+o].size() > 0 && expq[c*5+o][0] == f) begin
          ok = 1'b1;
          s = c;
        end
      end
      chk(ok, "R5", "head flit is the front of a packet routed here", int'(f), o);
      if (ok) begin
        void'(expq[s*5+o].pop_front());
        if (o == 0) head_log.push_back(s);
        if (f[FW-1:FW-2] != 2'b11) cur_src[o] = s;
      end
    end else begin
      s = cur_src[o];
      ok = (expq[s*5+o].size() > 0) && (expq[s*5+o][0] == f);
      chk(ok, "R6", "flit continues the reserved packet",
          int'(f), (expq[s*5+o].size() > 0) ? int'(expq[s*5+o][0]) : -1);
      if (ok) void'(expq[s*5+o].pop_front());
      if (f[FW-1]) cur_src[o] = -1;
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      cur_src[i] = -1; sent_last[i] = 0; prev_stall[i] = 0; delivered[i] = 0;
    end
    forever begin
      @(negedge clk);
      cycle++;
      if (cycle > WD) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycle, WD);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
      for (int i = 0; i < 5; i++) begin
        if (sent_last[i]) void'(sendq[i].pop_front());
        sent_last[i] = 0;
        in_valid[i] = rst_n && (sendq[i].size() > 0);
        in_flit[i*FW +: FW] = (sendq[i].size() > 0) ? sendq[i][0] : '0;
      end
      for (int o = 0; o < 5; o++) begin
        if (rdy_mode == 0) out_ready[o] = 1'b1;
        else if (rdy_mode == 1) out_ready[o] = ($urandom_range(3) != 0);
        else out_ready[o] = rdy_force[o];
      end
      #1;
      if (rst_n) begin
        for (int i = 0; i < 5; i++) sent_last[i] = in_valid[i] && in_ready[i];
        for (int o = 0; o < 5; o++) begin
          logic [FW-1:0] f;
          f = out_flit[o*FW +: FW];
          if (prev_stall[o])
            chk(out_valid[o] && f == prev_flit[o], "R8", "stalled flit held", int'(f), int'(prev_flit[o]));
          prev_stall[o] = out_valid[o] && !out_ready[o];
          prev_flit[o] = f;
          if (out_valid[o] && out_ready[o]) model_take(o, f);
        end
      end
    end
  end

  task automatic step;
    @(negedge clk);
    #5;
  endtask

  task automatic drain;
    bit busy;
    busy = 1'b1;
    while (busy) begin
      step();
      busy = 1'b0;
      for (int i = 0; i < 5; i++) if (sendq[i].size() > 0) busy = 1'b1;
      for (int j = 0; j < 25; j++) if (expq[j].size() > 0) busy = 1'b1;
      if (out_valid != 0) busy = 1'b1;
    end
    repeat (2) step();
  endtask

  task automatic clear_counts;
    for (int o = 0; o < 5; o++) delivered[o] = 0;
  endtask

  task automatic route_case(int src, int dx, int dy, int port, string req, int tag);
    int tot;
    clear_counts();
    send_pkt(src, dx, dy, 3, tag);
    drain();
    tot = delivered[0] + delivered[1] + delivered[2] + delivered[3] + delivered[4];
    chk(delivered[port] == 3 && tot == 3, req, "flits on selected port", delivered[port], 3);
  endtask

  initial begin
    int tag;
    tag = 1;
    repeat (3) step();
    // R1: reset state
    chk(out_valid == 5'h00, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 5'h1f, "R1", "in_ready in reset", int'(in_ready), 'h1f);
    rst_n = 1'b1;
    repeat (3) step();
    chk(out_valid == 5'h00 && in_ready == 5'h1f, "R1", "idle after reset",
        int'({out_valid, in_ready}), 'h1f);

    // R2/R3/R4 routing
    rdy_mode = 0;
    route_case(0, 3, 0, 2, "R2", tag++);
    route_case(0, 5, 7, 2, "R2", tag++);
    route_case(0, 0, 6, 4, "R2", tag++);
    route_case(1, 1, 0, 4, "R2", tag++);
    route_case(0, 2, 5, 1, "R3", tag++);
    route_case(4, 2, 0, 3, "R3", tag++);
    route_case(0, 2, 2, 0, "R4", tag++);
    route_case(3, 2, 2, 0, "R4", tag++);

    // R8: backpressure
    rdy_mode = 2; rdy_force = 5'b11011;
    clear_counts();
    send_pkt(0, 4, 2, 6, tag++);
    repeat (10) step();
    chk(out_valid[2] == 1'b1, "R8", "east offers while blocked", out_valid[2], 1);
    chk(in_ready[0] == 1'b0, "R8", "full local queue drops in_ready", in_ready[0], 0);
    chk(delivered[2] == 0, "R8", "nothing left while not ready", delivered[2], 0);
    rdy_force = 5'b11111;
    drain();
    chk(delivered[2] == 6, "R8", "packet delivered after release", delivered[2], 6);

    // R6: contention for east with random ready
    rdy_mode = 1;
    clear_counts();
    send_pkt(1, 4, 3, 4, tag++);
    send_pkt(3, 5, 1, 4, tag++);
    send_pkt(4, 6, 2, 5, tag++);
    send_pkt(0, 7, 0, 3, tag++);
    drain();
    chk(delivered[2] == 16, "R6", "all contending flits on east", delivered[2], 16);

    // R7/R10: round robin of single-flit packets on local
    rdy_mode = 0;
    send_pkt(0, 2, 2, 1, tag++);
    drain();
    head_log.delete();
    clear_counts();
    for (int r = 0; r < 2; r++)
      for (int s = 1; s < 5; s++) send_pkt(s, 2, 2, 1, tag++);
    drain();
    chk(head_log.size() == 8, "R7", "grant count", head_log.size(), 8);
    for (int k = 0; k < 8; k++)
      chk(k < head_log.size() && head_log[k] == (k % 4) + 1, "R7", "grant order",
          (k < head_log.size()) ? head_log[k] : -1, (k % 4) + 1);
    chk(delivered[0] == 8, "R10", "single-flit packets each reopen local", delivered[0], 8);

    // R9: full throughput
    east_cyc.delete();
    send_pkt(0, 5, 2, 6, tag++);
    drain();
    chk(east_cyc.size() == 6, "R9", "flit count", east_cyc.size(), 6);
    if (east_cyc.size() == 6)
      chk(east_cyc[5] - east_cyc[0] == 5, "R9", "cycles first to last flit",
          east_cyc[5] - east_cyc[0], 5);

    // R5: mixed random traffic
    rdy_mode = 1;
    clear_counts();
    begin
      int total;
      total = 0;
      for (int n = 0; n < 60; n++) begin
        int len;
        len = $urandom_range(5, 1);
        send_pkt($urandom_range(4), $urandom_range(7), $urandom_range(7), len, tag++);
        total += len;
        if (n % 6 == 5) step();
      end
      drain();
      chk(delivered[0] + delivered[1] + delivered[2] + delivered[3] + delivered[4] == total,
          "R5", "every random flit delivered",
          delivered[0] + delivered[1] + delivered[2] + delivered[3] + delivered[4], total);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule